// File: doc/BRIEF.md
# Timing-Protocol Transmit Template Buffer

This block keeps a small set of fixed timing-protocol frame templates in on-chip storage and sends one of them on request. A host reaches every template word, the per-slot frame lengths, the captured timestamps and the control registers through a simple word-wide register bus. The host picks a slot by writing its index to a send register. The chosen template is then streamed, one byte per accepted beat, to a downstream transmit arbiter over a valid/ready byte interface.

The block samples the local real-time counter's nanosecond value on the cycle the downstream side accepts the frame's first byte. It stores that value in a timestamp register that belongs to the slot. The completion interrupt is raised only after the last byte is accepted, so the timestamp is already in place when software reacts. The interrupt is a sticky status bit that the host clears by writing a one to it. A request made during a frame waits and is issued once the frame ends.

Top module: `ptp_tx_tmpl_buf`

## Requirements
- R1: There are seven template slots of 64 bytes, held as sixteen 32-bit words each. Word w of slot s is at bus address s*16+w, and byte k of a slot sits in word k/4 at bits 8*(k mod 4)+7 down to 8*(k mod 4). Reads return data on `bus_rdata` one cycle after the read strobe. Template addresses 0x70-0x7F read as zero.
- R2: The frame length of slot s is at address 0x80+s and resets to 64. A write of a value outside 1..64 leaves the length unchanged.
- R3: Writing bits [3:0] of address 0x90 requests slot 0..6. Index values 7..15 are ignored and start no frame.
- R4: A frame presents bytes 0..len-1 of the slot in order, with `tx_last` on the final byte. While `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold steady.
- R5: A request made while a frame is running is held and started after that frame ends. A newer held request replaces an older one that has not yet started.
- R6: The value of `rtc_ns` in the cycle the first byte is accepted is stored as the slot's timestamp, readable at address 0x88+s.
- R7: `irq` (status address 0x91, bit 0) is set in the cycle after the last byte is accepted. It stays set until a write to 0x91 with bit 0 set. When a set and a clear fall in the same cycle, the set wins.
- R8: While a slot is being sent, host writes to its template words and its length are dropped. Writes to other slots still take effect.
- R9: After reset `tx_valid` and `irq` are low and all timestamps read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the strobe |
| rtc_ns | input | 32 | Nanosecond field of the local real-time counter |
| tx_valid | output | 1 | Byte available to the arbiter |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | Arbiter accepts the byte |
| irq | output | 1 | Sticky transmit-done interrupt |

## Verification
The embedded assertions check every cycle that a stalled byte stays unchanged and that the active slot index is in range. They also check that the length of the slot being sent cannot change mid-frame, that the timestamp takes the counter value on the first accepted byte, and that each completed frame has already captured its timestamp when `irq` rises. Only the bench's scenarios can show the rest: the byte order and the frame lengths, that bad indices and out-of-range lengths are ignored, the replacement of a held request by a newer one, and that writes to the active slot are dropped while writes to other slots land.

// File: rtl/tx_tmpl_pkg.sv
package tx_tmpl_pkg;
   typedef enum logic [1:0] {
      K_LEN  = 2'd0,
      K_TS   = 2'd1,
      K_CTL  = 2'd2,
      K_NONE = 2'd3
   } reg_kind_e;

   localparam int CTL_SEND = 0;
   localparam int CTL_STAT = 1;
endpackage

// File: rtl/tmpl_store.sv
module tmpl_store #(
   parameter int NUM_SLOTS  = 7,
   parameter int WORDS      = 16,
   parameter int DATA_W     = 32,
   parameter int SLOT_W     = 3,
   parameter int WIDX_W     = 4,
   parameter int LEN_W      = 7,
   parameter int SLOT_BYTES = 64
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                wr_en,
   input  logic [SLOT_W-1:0]                   wr_slot,
   input  logic [WIDX_W-1:0]                   wr_word,
   input  logic [DATA_W-1:0]                   wr_data,
   input  logic                                len_we,
   input  logic [SLOT_W-1:0]                   len_slot,
   input  logic [DATA_W-1:0]                   len_wdata,
   input  logic                                busy,
   input  logic [SLOT_W-1:0]                   act_slot,
   input  logic [SLOT_W-1:0]                   hr_slot,
   input  logic [WIDX_W-1:0]                   hr_word,
   output logic [DATA_W-1:0]                   hr_data,
   input  logic [WIDX_W-1:0]                   st_word,
   output logic [DATA_W-1:0]                   st_data,
   output logic [NUM_SLOTS-1:0][LEN_W-1:0]     len_q
);
   logic [DATA_W-1:0] mem [NUM_SLOTS][WORDS];
   logic              wr_ok;
   logic              len_ok;

   assign wr_ok  = wr_en && (wr_slot < SLOT_W'(NUM_SLOTS)) && !(busy && act_slot == wr_slot);
   assign len_ok = (len_wdata != '0) && (len_wdata <= DATA_W'(SLOT_BYTES));

   always_ff @(posedge clk) begin
      if (wr_ok) mem[wr_slot][wr_word] <= wr_data;
   end

   assign hr_data = (hr_slot < SLOT_W'(NUM_SLOTS)) ? mem[hr_slot][hr_word] : '0;
   assign st_data = mem[act_slot][st_word];

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_len
      always_ff @(posedge clk) begin
         if (!rst_n)
            len_q[s] <= LEN_W'(SLOT_BYTES);
         else if (len_we && len_ok && len_slot == SLOT_W'(s) && !(busy && act_slot == SLOT_W'(s)))
            len_q[s] <= LEN_W'(len_wdata);
      end
   end

   // R8: the length of the slot on the wire stays fixed for the whole frame
   a_r8_active_len_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && act_slot == $past(act_slot)) |-> $stable(len_q[act_slot]));
endmodule

// File: rtl/tx_streamer.sv
module tx_streamer #(
   parameter int NUM_SLOTS  = 7,
   parameter int SLOT_W     = 3,
   parameter int WIDX_W     = 4,
   parameter int LEN_W      = 7,
   parameter int DATA_W     = 32,
   parameter int SLOT_BYTES = 64,
   parameter bit LITTLE_END = 1'b1
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            req_en,
   input  logic [SLOT_W:0]                 req_idx,
   input  logic [NUM_SLOTS-1:0][LEN_W-1:0] len_q,
   input  logic [DATA_W-1:0]               word_data,
   input  logic                            tx_ready,
   output logic                            tx_valid,
   output logic [7:0]                      tx_data,
   output logic                            tx_last,
   output logic                            busy,
   output logic [SLOT_W-1:0]               act_slot,
   output logic [WIDX_W-1:0]               word_idx,
   output logic                            first_fire,
   output logic                            last_fire
);
   localparam int BPW     = DATA_W / 8;
   localparam int BYTE_SH = $clog2(BPW);
   localparam int BCNT_W  = $clog2(SLOT_BYTES);

   logic              busy_q;
   logic [SLOT_W-1:0] act_q;
   logic [BCNT_W-1:0] bcnt;
   logic              pend_v;
   logic [SLOT_W-1:0] pend_idx;
   logic              req_ok;
   logic              fire;
   logic              is_last;
   logic              launch;
   logic [LEN_W-1:0]  cur_len;
   logic [BYTE_SH-1:0] lane;

   assign req_ok  = req_en && (req_idx < (SLOT_W+1)'(NUM_SLOTS));
   assign cur_len = len_q[act_q];
   assign is_last = ({{(LEN_W-BCNT_W){1'b0}}, bcnt} == cur_len - LEN_W'(1));
   assign fire    = busy_q && tx_ready;
   assign launch  = !busy_q && pend_v;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         act_q    <= '0;
         bcnt     <= '0;
         pend_v   <= 1'b0;
         pend_idx <= '0;
      end else begin
         if (fire) begin
            if (is_last) begin
               busy_q <= 1'b0;
               bcnt   <= '0;
            end else begin
               bcnt <= bcnt + 1'b1;
            end
         end else if (launch) begin
            busy_q <= 1'b1;
            act_q  <= pend_idx;
            bcnt   <= '0;
         end
         if (req_ok) begin
            pend_v   <= 1'b1;
            pend_idx <= req_idx[SLOT_W-1:0];
         end else if (launch) begin
            pend_v <= 1'b0;
         end
      end
   end

   assign word_idx = bcnt[BYTE_SH +: WIDX_W];
   assign lane     = bcnt[BYTE_SH-1:0];

   if (LITTLE_END) begin : g_le
      assign tx_data = word_data[int'(lane)*8 +: 8];
   end else begin : g_be
      assign tx_data = word_data[(BPW-1-int'(lane))*8 +: 8];
   end

   assign tx_valid   = busy_q;
   assign tx_last    = busy_q && is_last;
   assign busy       = busy_q;
   assign act_slot   = act_q;
   assign first_fire = fire && (bcnt == '0);
   assign last_fire  = fire && is_last;

   // R4: a stalled byte must not change before it is taken
   a_r4_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));
   // R3: only slots 0..6 ever become active
   a_r3_active_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (act_q < SLOT_W'(NUM_SLOTS)));
   // R3: a rejected index leaves nothing pending from an idle state
   a_r3_bad_req_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (req_en && !req_ok && !pend_v && !busy_q) |=> !pend_v);
   // R5: a frame that ends with a held request starts it after one idle cycle
   a_r5_pending_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (last_fire && pend_v) |=> ##1 busy_q);
endmodule

// File: rtl/ts_capture.sv
module ts_capture #(
   parameter int NUM_SLOTS = 7,
   parameter int SLOT_W    = 3,
   parameter int TS_W      = 32
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           first_fire,
   input  logic                           last_fire,
   input  logic [SLOT_W-1:0]              act_slot,
   input  logic [TS_W-1:0]                rtc,
   input  logic                           clr,
   output logic [NUM_SLOTS-1:0][TS_W-1:0] ts_q,
   output logic                           irq
);
   logic cap_done;

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_ts
      always_ff @(posedge clk) begin
         if (!rst_n)
            ts_q[s] <= '0;
         else if (first_fire && act_slot == SLOT_W'(s))
            ts_q[s] <= rtc;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq      <= 1'b0;
         cap_done <= 1'b0;
      end else begin
         if (last_fire)  irq <= 1'b1;
         else if (clr)   irq <= 1'b0;
         if (last_fire)       cap_done <= 1'b0;
         else if (first_fire) cap_done <= 1'b1;
      end
   end

   // R6: the stored stamp is the counter value of the first accepted byte
   a_r6_stamp_taken: assert property (@(posedge clk) disable iff (!rst_n)
      first_fire |=> (ts_q[$past(act_slot)] == $past(rtc)));
   // R7: no completion without a stamp already captured for this frame
   a_r7_stamp_before_irq: assert property (@(posedge clk) disable iff (!rst_n)
      last_fire |-> (cap_done || first_fire));
   // R7: completion raises the interrupt on the next cycle
   a_r7_irq_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      last_fire |=> irq);
endmodule

// File: rtl/ptp_tx_tmpl_buf.sv
module ptp_tx_tmpl_buf
   import tx_tmpl_pkg::*;
#(
   parameter int NUM_SLOTS  = 7,
   parameter int SLOT_BYTES = 64,
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 8,
   parameter int TS_W       = 32,
   parameter bit LITTLE_END = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [TS_W-1:0]   rtc_ns,
   output logic              tx_valid,
   output logic [7:0]        tx_data,
   output logic              tx_last,
   input  logic              tx_ready,
   output logic              irq
);
   localparam int BPW    = DATA_W / 8;
   localparam int WORDS  = SLOT_BYTES / BPW;
   localparam int WIDX_W = $clog2(WORDS);
   localparam int SLOT_W = $clog2(NUM_SLOTS + 1);
   localparam int LEN_W  = $clog2(SLOT_BYTES + 1);

   if (DATA_W % 8 != 0 || DATA_W < 16) begin : g_bad_width
      $error("DATA_W must be a multiple of 8 and at least 16");
   end
   if ((SLOT_BYTES % BPW) != 0 || (1 << WIDX_W) != WORDS) begin : g_bad_depth
      $error("SLOT_BYTES must be a power-of-two number of words");
   end
   if (WIDX_W + SLOT_W > ADDR_W - 1 || SLOT_W + 2 > ADDR_W - 1) begin : g_bad_addr
      $error("ADDR_W too small for the template and register regions");
   end
   if (TS_W > DATA_W || NUM_SLOTS < 2) begin : g_bad_misc
      $error("TS_W must fit the bus and NUM_SLOTS must be at least 2");
   end

   logic              is_reg;
   logic              tmpl_hi_zero;
   logic              reg_hi_zero;
   logic [SLOT_W-1:0] t_slot;
   logic [WIDX_W-1:0] t_word;
   logic [SLOT_W-1:0] r_slot;
   reg_kind_e         r_kind;
   logic              reg_hit;
   logic              tmpl_we, len_we, send_we, clr_we;

   assign is_reg       = bus_addr[ADDR_W-1];
   assign tmpl_hi_zero = ((bus_addr[ADDR_W-2:0] >> (WIDX_W + SLOT_W)) == '0);
   assign reg_hi_zero  = ((bus_addr[ADDR_W-2:0] >> (SLOT_W + 2)) == '0);
   assign t_slot       = bus_addr[WIDX_W +: SLOT_W];
   assign t_word       = bus_addr[WIDX_W-1:0];
   assign r_slot       = bus_addr[SLOT_W-1:0];
   assign r_kind       = reg_kind_e'(bus_addr[SLOT_W +: 2]);
   assign reg_hit      = bus_sel && is_reg && reg_hi_zero;
   assign tmpl_we      = bus_sel && bus_wr && !is_reg && tmpl_hi_zero;
   assign len_we       = reg_hit && bus_wr && (r_kind == K_LEN);
   assign send_we      = reg_hit && bus_wr && (r_kind == K_CTL) && (r_slot == SLOT_W'(CTL_SEND));
   assign clr_we       = reg_hit && bus_wr && (r_kind == K_CTL) && (r_slot == SLOT_W'(CTL_STAT)) && bus_wdata[0];

   logic [NUM_SLOTS-1:0][LEN_W-1:0] len_q;
   logic [NUM_SLOTS-1:0][TS_W-1:0]  ts_q;
   logic [DATA_W-1:0]               hr_data, st_data;
   logic                            busy, first_fire, last_fire;
   logic [SLOT_W-1:0]               act_slot;
   logic [WIDX_W-1:0]               word_idx;

   tmpl_store #(
      .NUM_SLOTS(NUM_SLOTS), .WORDS(WORDS), .DATA_W(DATA_W), .SLOT_W(SLOT_W),
      .WIDX_W(WIDX_W), .LEN_W(LEN_W), .SLOT_BYTES(SLOT_BYTES)
   ) u_store (
      .clk, .rst_n,
      .wr_en(tmpl_we), .wr_slot(t_slot), .wr_word(t_word), .wr_data(bus_wdata),
      .len_we, .len_slot(r_slot), .len_wdata(bus_wdata),
      .busy, .act_slot,
      .hr_slot(t_slot), .hr_word(t_word), .hr_data,
      .st_word(word_idx), .st_data,
      .len_q
   );

   tx_streamer #(
      .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .WIDX_W(WIDX_W), .LEN_W(LEN_W),
      .DATA_W(DATA_W), .SLOT_BYTES(SLOT_BYTES), .LITTLE_END(LITTLE_END)
   ) u_stream (
      .clk, .rst_n,
      .req_en(send_we), .req_idx(bus_wdata[SLOT_W:0]),
      .len_q, .word_data(st_data), .tx_ready,
      .tx_valid, .tx_data, .tx_last,
      .busy, .act_slot, .word_idx, .first_fire, .last_fire
   );

   ts_capture #(
      .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .TS_W(TS_W)
   ) u_ts (
      .clk, .rst_n, .first_fire, .last_fire, .act_slot,
      .rtc(rtc_ns), .clr(clr_we), .ts_q, .irq
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_rdata <= '0;
      end else if (bus_sel && !bus_wr) begin
         if (!is_reg)
            bus_rdata <= tmpl_hi_zero ? hr_data : '0;
         else if (!reg_hi_zero || r_slot >= SLOT_W'(NUM_SLOTS))
            bus_rdata <= '0;
         else begin
            case (r_kind)
               K_LEN:   bus_rdata <= DATA_W'(len_q[r_slot]);
               K_TS:    bus_rdata <= DATA_W'(ts_q[r_slot]);
               K_CTL:   bus_rdata <= (r_slot == SLOT_W'(CTL_STAT)) ? DATA_W'(irq) : '0;
               default: bus_rdata <= '0;
            endcase
         end
      end
   end

   // R9: nothing is offered and no interrupt is pending straight after reset
   a_r9_quiet_after_reset: assert property (@(posedge clk)
      $past(!rst_n) |-> (!tx_valid && !irq));
endmodule

// File: tb/ptp_tx_tmpl_buf_test.sv
module ptp_tx_tmpl_buf_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] rtc = '0;
   logic        tx_valid;
   logic [7:0]  tx_data;
   logic        tx_last;
   logic        tx_ready = 1'b0;
   logic        irq;

   int total = 0;
   int bad = 0;

   ptp_tx_tmpl_buf uut (
      .clk, .rst_n, .bus_sel, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
      .rtc_ns(rtc), .tx_valid, .tx_data, .tx_last, .tx_ready, .irq
   );

   initial forever #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) rtc <= rtc + 32'd1;

   // ---- byte monitor, also drives tx_ready ----
   int          ready_mode = 0;
   int          mcyc = 0;
   int          rx_cnt = 0;
   logic [7:0]  rx_byte [256];
   logic        rx_lst  [256];
   logic [31:0] rx_rtc  [256];
   bit          irq_chk_pend = 0;
   bit          irq_after = 0;

   always begin
      @(negedge clk);
      mcyc++;
      if (irq_chk_pend) begin
         irq_after    = irq;
         irq_chk_pend = 0;
      end
      case (ready_mode)
         0:       tx_ready = 1'b1;
         1:       tx_ready = mcyc[0];
         default: tx_ready = (mcyc % 4 == 3);
      endcase
      #1;
      if (tx_valid && tx_ready && rx_cnt < 256) begin
         rx_byte[rx_cnt] = tx_data;
         rx_lst[rx_cnt]  = tx_last;
         rx_rtc[rx_cnt]  = rtc;
         rx_cnt++;
         if (tx_last) irq_chk_pend = 1;
      end
   end

   task automatic summary();
      $display("test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
      $finish;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_byte(input int s, input int k);
      return 8'(s * 37 + k * 5 + 3);
   endfunction

   function automatic logic [31:0] exp_word(input int s, input int w);
      return {exp_byte(s, 4*w+3), exp_byte(s, 4*w+2), exp_byte(s, 4*w+1), exp_byte(s, 4*w)};
   endfunction

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_sel = 1'b0;
      d = bus_rdata;
   endtask

   task automatic wait_bytes(input int n, input string req);
      for (int i = 0; i < 3000 && rx_cnt < n; i++) @(negedge clk);
      repeat (6) @(negedge clk);
      chk(rx_cnt == n, req, "byte count", 32'(rx_cnt), 32'(n));
   endtask

   task automatic cmp_bytes(input int base, input int s, input int n, input string req);
      int errs = 0;
      logic [7:0] a = '0, e = '0;
      for (int k = 0; k < n; k++) begin
         if (rx_byte[base+k] !== exp_byte(s, k) || rx_lst[base+k] !== (k == n-1)) begin
            if (errs == 0) begin a = rx_byte[base+k]; e = exp_byte(s, k); end
            errs++;
         end
      end
      chk(errs == 0, req, "frame bytes/last", 32'(a), 32'(e));
   endtask

   // ---- scenarios ----
   task automatic t_reset();
      logic [31:0] d;
      @(negedge clk);
      chk(tx_valid == 1'b0, "R9", "tx_valid after reset", 32'(tx_valid), 0);
      chk(irq == 1'b0, "R9", "irq after reset", 32'(irq), 0);
      bus_read(8'h80, d);
      chk(d == 32'd64, "R2", "reset length slot0", d, 64);
      bus_read(8'h8B, d);
      chk(d == 32'd0, "R9", "reset timestamp slot3", d, 0);
   endtask

   task automatic t_fill();
      logic [31:0] d;
      for (int s = 0; s < 7; s++)
         for (int w = 0; w < 16; w++)
            bus_write(8'(s*16 + w), exp_word(s, w));
      bus_read(8'h00, d);
      chk(d == exp_word(0, 0), "R1", "slot0 word0", d, exp_word(0, 0));
      bus_read(8'h6F, d);
      chk(d == exp_word(6, 15), "R1", "slot6 word15", d, exp_word(6, 15));
      bus_read(8'h37, d);
      chk(d == exp_word(3, 7), "R1", "slot3 word7", d, exp_word(3, 7));
      bus_write(8'h70, 32'hA5A5A5A5);
      bus_read(8'h70, d);
      chk(d == 32'd0, "R1", "unmapped template word", d, 0);
   endtask

   task automatic t_len_cfg();
      logic [31:0] d;
      bus_write(8'h82, 32'd10);
      bus_read(8'h82, d);
      chk(d == 32'd10, "R2", "length write 10", d, 10);
      bus_write(8'h82, 32'd0);
      bus_read(8'h82, d);
      chk(d == 32'd10, "R2", "length write 0 ignored", d, 10);
      bus_write(8'h82, 32'd65);
      bus_read(8'h82, d);
      chk(d == 32'd10, "R2", "length write 65 ignored", d, 10);
   endtask

   task automatic t_frame(input int s, input int n, input int mode);
      logic [31:0] d;
      ready_mode = mode;
      rx_cnt = 0;
      irq_after = 0;
      bus_write(8'h90, 32'(s));
      wait_bytes(n, "R4");
      cmp_bytes(0, s, n, "R4");
      chk(irq_after == 1'b1, "R7", "irq one cycle after last byte", 32'(irq_after), 1);
      bus_read(8'(8'h88 + s), d);
      chk(d == rx_rtc[0], "R6", "timestamp of first accepted byte", d, rx_rtc[0]);
      bus_read(8'h91, d);
      chk(d == 32'd1, "R7", "status sticky", d, 1);
      bus_write(8'h91, 32'd1);
      bus_read(8'h91, d);
      chk(d == 32'd0 && irq == 1'b0, "R7", "status cleared by write-one", d, 0);
   endtask

   task automatic t_bad_req();
      ready_mode = 0;
      rx_cnt = 0;
      bus_write(8'h90, 32'd7);
      bus_write(8'h90, 32'd12);
      repeat (20) @(negedge clk);
      chk(rx_cnt == 0 && tx_valid == 1'b0, "R3", "indices 7 and 12 ignored", 32'(rx_cnt), 0);
   endtask

   task automatic t_pending();
      bus_write(8'h80, 32'd4);
      bus_write(8'h81, 32'd5);
      bus_write(8'h83, 32'd6);
      ready_mode = 2;
      rx_cnt = 0;
      bus_write(8'h90, 32'd0);
      bus_write(8'h90, 32'd1);
      bus_write(8'h90, 32'd3);
      wait_bytes(10, "R5");
      cmp_bytes(0, 0, 4, "R5");
      cmp_bytes(4, 3, 6, "R5");
      bus_write(8'h91, 32'd1);
   endtask

   task automatic t_protect();
      logic [31:0] d;
      ready_mode = 2;
      rx_cnt = 0;
      bus_write(8'h90, 32'd4);
      repeat (5) @(negedge clk);
      bus_write(8'h40, 32'hDEADBEEF);
      bus_write(8'h84, 32'd8);
      bus_write(8'h60, 32'h11223344);
      wait_bytes(64, "R8");
      cmp_bytes(0, 4, 64, "R8");
      bus_read(8'h40, d);
      chk(d == exp_word(4, 0), "R8", "active slot word write dropped", d, exp_word(4, 0));
      bus_read(8'h84, d);
      chk(d == 32'd64, "R8", "active slot length write dropped", d, 64);
      bus_read(8'h60, d);
      chk(d == 32'h11223344, "R8", "idle slot write lands", d, 32'h11223344);
      bus_write(8'h91, 32'd1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_fill();
      t_len_cfg();
      t_frame(2, 10, 0);      // R4 R6 R7 unstalled
      t_frame(5, 64, 2);      // R4 heavy stall, full length
      bus_write(8'h86, 32'd1);
      t_frame(6, 1, 1);       // R4 single-byte frame
      t_bad_req();
      t_pending();
      t_protect();
      summary();
      $finish;
   end
endmodule